// File: doc/BRIEF.md
# Masked Calendar Alarm Comparator

This block watches a running BCD calendar and raises alarms when it reaches programmed values. The calendar arrives on input ports: seconds, minutes, hours, an afternoon bit, day of month, weekday and a 15-bit sub-second count. A tick strobe marks each sub-second step. The block compares these values against a set of independent alarm channels, two by default.

Each channel is set up by a 32-bit alarm word. The word holds the seconds, minutes, hour and day values to compare. It also holds an ignore bit for each of those fields, an afternoon bit, and a bit that selects whether the day field is compared with the day of month or with the weekday. A separate sub-second value comes with a 4-bit width code, which sets how many low sub-second bits take part in the compare.

When every field that is not ignored matches on a tick, an enabled channel sets a sticky flag. The flag stays set until that channel's clear strobe. The interrupt output is the flag gated by the channel's interrupt enable. The calendar counter, register decoding and write protection are handled elsewhere.

Top module: `alarm_match_top`

## Requirements
- R1: On a tick, with no ignore bits set and sub-second code 0, an enabled channel's flag is high from the next clock edge only when the seconds (word bits [6:0]), minutes ([14:8]) and hour ([21:16]) equal the calendar values bit for bit, and day ([29:24]) does too. The compare is raw BCD bit equality, so binary 45 (0x2D) does not match BCD 45 (0x45).
- R2: Word bit 7 excludes seconds from the compare. Bit 15 excludes minutes, bit 23 excludes the hour together with the afternoon bit, and bit 31 excludes the day field.
- R3: With word bit 30 set, the 6-bit day field is compared with the 3-bit weekday zero-extended. With bit 30 clear, it is compared with the day of month.
- R4: Sub-second code 0 ignores the sub-second value. A code n from 1 to 14 compares bits [n-1:0] of the alarm's sub-second value with the calendar's. Code 15 compares all bits [14:0].
- R5: In 12-hour mode (mode_12h=1) the afternoon bit, word bit 22, must equal cal_pm for the hour to match. In 24-hour mode it is ignored.
- R6: Matching happens only on cycles where tick is high. A match without a tick leaves the flag unchanged.
- R7: A channel whose enable is low never sets its flag.
- R8: A flag stays set across later ticks until its clear strobe. A clear alone drops the flag at the next edge. A set and a clear in the same cycle leave the flag set.
- R9: A channel's interrupt output is high exactly when its flag is high and its interrupt enable is high.
- R10: The channels are independent. Each uses only its own word, sub-second setting, enable, clear and interrupt enable.
- R11: Synchronous reset clears all flags and interrupt outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Sub-second step strobe; the compare is evaluated here |
| mode_12h | input | 1 | 1 selects 12-hour mode |
| cal_sec | input | 7 | Current seconds, BCD |
| cal_min | input | 7 | Current minutes, BCD |
| cal_hour | input | 6 | Current hour, BCD |
| cal_pm | input | 1 | Current afternoon bit |
| cal_day | input | 6 | Current day of month, BCD |
| cal_wday | input | 3 | Current weekday |
| cal_ss | input | SS_W | Current sub-second count |
| alm_word | input | N_ALARMS*32 | Alarm words, channel i at [32*i +: 32] |
| alm_ss_val | input | N_ALARMS*SS_W | Alarm sub-second values |
| alm_ss_code | input | N_ALARMS*SS_CODE_W | Sub-second compare width codes |
| alm_en | input | N_ALARMS | Per-channel enable |
| alm_ie | input | N_ALARMS | Per-channel interrupt enable |
| alm_clr | input | N_ALARMS | Per-channel flag clear strobe |
| alm_flag | output | N_ALARMS | Sticky match flags |
| alm_irq | output | N_ALARMS | Interrupt outputs |

## Verification
The bench builds the block with its default parameters: two channels, a 15-bit sub-second count and a 4-bit width code. The full 15-bit count makes the two widest codes, 14 and 15, distinguishable, because an alarm value that differs only in bit 14 matches under one and fails under the other. Having two channels makes it possible to show that one fires while the other stays quiet on the same tick.

// File: rtl/alarm_match_pkg.sv
package alarm_match_pkg;

    localparam int unsigned ALM_WORD_W = 32;

    // Alarm word decoded MSB first; the packed order mirrors the bit layout.
    typedef struct packed {
        logic       ign_day;   // [31]
        logic       day_is_wd; // [30]
        logic [5:0] day;       // [29:24]
        logic       ign_hour;  // [23]
        logic       pm;        // [22]
        logic [5:0] hour;      // [21:16]
        logic       ign_min;   // [15]
        logic [6:0] min;       // [14:8]
        logic       ign_sec;   // [7]
        logic [6:0] sec;       // [6:0]
    } alm_fields_t;

    // Mask that keeps the low n sub-second bits.
    function automatic logic [31:0] ss_keep_mask(input int unsigned n);
        if (n >= 32)
            return '1;
        return (32'd1 << n) - 32'd1;
    endfunction

endpackage

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp
    import alarm_match_pkg::*;
#(
    parameter int unsigned SS_W      = 15,
    parameter int unsigned SS_CODE_W = 4
) (
    input  logic [ALM_WORD_W-1:0] word,
    input  logic [SS_W-1:0]       ss_val,
    input  logic [SS_CODE_W-1:0]  ss_code,
    input  logic                  mode_12h,
    input  logic [6:0]            cal_sec,
    input  logic [6:0]            cal_min,
    input  logic [5:0]            cal_hour,
    input  logic                  cal_pm,
    input  logic [5:0]            cal_day,
    input  logic [2:0]            cal_wday,
    input  logic [SS_W-1:0]       cal_ss,
    output logic                  match
);
    alm_fields_t     f;
    logic [SS_W-1:0] keep;
    logic [5:0]      day_ref;
    logic            sec_ok, min_ok, hour_ok, day_ok, ss_ok;

    assign f    = alm_fields_t'(word);
    assign keep = SS_W'(ss_keep_mask(32'(ss_code)));

    always_comb begin
        day_ref = f.day_is_wd ? {3'b000, cal_wday} : cal_day;
        sec_ok  = f.ign_sec  | (f.sec == cal_sec);
        min_ok  = f.ign_min  | (f.min == cal_min);
        hour_ok = f.ign_hour | ((f.hour == cal_hour) && (!mode_12h || (f.pm == cal_pm)));
        day_ok  = f.ign_day  | (f.day == day_ref);
        ss_ok   = ((ss_val ^ cal_ss) & keep) == '0;
        match   = sec_ok & min_ok & hour_ok & day_ok & ss_ok;
    end

    // R2 / R4: every field ignored and code 0 must always match
    always_comb begin
        if (f.ign_sec && f.ign_min && f.ign_hour && f.ign_day && (ss_code == '0))
            assert_all_ignored_match_R2: assert (match);
    end

endmodule

// File: rtl/alarm_flag_reg.sv
module alarm_flag_reg (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic en,
    input  logic match,
    input  logic clr,
    input  logic ie,
    output logic flag,
    output logic irq
);
    logic hit;

    assign hit = tick & en & match;

    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (hit)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end

    assign irq = flag & ie;

    assert_disabled_no_set_R7: assert property (@(posedge clk) disable iff (rst)
        (!en && !flag) |=> !flag);

    assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag);

    assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (clr && !(tick && en && match)) |=> !flag);

    assert_no_tick_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!tick && !flag) |=> !flag);

    assert_set_on_tick_R1: assert property (@(posedge clk) disable iff (rst)
        (tick && en && match) |=> flag);

endmodule

// File: rtl/alarm_match_top.sv
module alarm_match_top
    import alarm_match_pkg::*;
#(
    parameter int unsigned N_ALARMS  = 2,
    parameter int unsigned SS_W      = 15,
    parameter int unsigned SS_CODE_W = 4
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            tick,
    input  logic                            mode_12h,
    input  logic [6:0]                      cal_sec,
    input  logic [6:0]                      cal_min,
    input  logic [5:0]                      cal_hour,
    input  logic                            cal_pm,
    input  logic [5:0]                      cal_day,
    input  logic [2:0]                      cal_wday,
    input  logic [SS_W-1:0]                 cal_ss,
    input  logic [N_ALARMS*ALM_WORD_W-1:0]  alm_word,
    input  logic [N_ALARMS*SS_W-1:0]        alm_ss_val,
    input  logic [N_ALARMS*SS_CODE_W-1:0]   alm_ss_code,
    input  logic [N_ALARMS-1:0]             alm_en,
    input  logic [N_ALARMS-1:0]             alm_ie,
    input  logic [N_ALARMS-1:0]             alm_clr,
    output logic [N_ALARMS-1:0]             alm_flag,
    output logic [N_ALARMS-1:0]             alm_irq
);
    logic [N_ALARMS-1:0] match;

    for (genvar i = 0; i < N_ALARMS; i++) begin : g_chan
        alarm_field_cmp #(
            .SS_W      (SS_W),
            .SS_CODE_W (SS_CODE_W)
        ) u_cmp (
            .word     (alm_word[i*ALM_WORD_W +: ALM_WORD_W]),
            .ss_val   (alm_ss_val[i*SS_W +: SS_W]),
            .ss_code  (alm_ss_code[i*SS_CODE_W +: SS_CODE_W]),
            .mode_12h (mode_12h),
            .cal_sec  (cal_sec),
            .cal_min  (cal_min),
            .cal_hour (cal_hour),
            .cal_pm   (cal_pm),
            .cal_day  (cal_day),
            .cal_wday (cal_wday),
            .cal_ss   (cal_ss),
            .match    (match[i])
        );

        alarm_flag_reg u_flag (
            .clk   (clk),
            .rst   (rst),
            .tick  (tick),
            .en    (alm_en[i]),
            .match (match[i]),
            .clr   (alm_clr[i]),
            .ie    (alm_ie[i]),
            .flag  (alm_flag[i]),
            .irq   (alm_irq[i])
        );
    end

    // R11: flags are clear on the cycle after reset
    assert_reset_clears_R11: assert property (@(posedge clk)
        rst |=> (alm_flag == '0));

    // R9: an interrupt never appears without its flag
    assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (rst)
        (alm_irq & ~alm_flag) == '0);

endmodule

// File: tb/sim_alarm_match_top.sv
module sim_alarm_match_top;
    localparam int N = 2;
    localparam int SW = 15;
    localparam int CW = 4;

    logic clk = 1'b0;
    logic rst, tick, mode_12h, cal_pm;
    logic [6:0] cal_sec, cal_min;
    logic [5:0] cal_hour, cal_day;
    logic [2:0] cal_wday;
    logic [SW-1:0] cal_ss;
    logic [N*32-1:0] alm_word;
    logic [N*SW-1:0] alm_ss_val;
    logic [N*CW-1:0] alm_ss_code;
    logic [N-1:0] alm_en, alm_ie, alm_clr, alm_flag, alm_irq;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    alarm_match_top #(.N_ALARMS(N), .SS_W(SW), .SS_CODE_W(CW)) u0 (
        .clk(clk), .rst(rst), .tick(tick), .mode_12h(mode_12h),
        .cal_sec(cal_sec), .cal_min(cal_min), .cal_hour(cal_hour), .cal_pm(cal_pm),
        .cal_day(cal_day), .cal_wday(cal_wday), .cal_ss(cal_ss),
        .alm_word(alm_word), .alm_ss_val(alm_ss_val), .alm_ss_code(alm_ss_code),
        .alm_en(alm_en), .alm_ie(alm_ie), .alm_clr(alm_clr),
        .alm_flag(alm_flag), .alm_irq(alm_irq)
    );

    typedef struct packed {
        logic [31:0] w;
        logic [3:0]  c;
        logic [14:0] v;
        logic        m12;
        logic        exp;
        logic [3:0]  rq;
    } vec_t;

    // Calendar for every vector: 11:30:45, day 15, weekday 3, sub-second 0x1234, pm 0
    localparam vec_t VEC [24] = '{
        '{32'h15113045, 4'd0,  15'h0000, 1'b0, 1'b1, 4'd1},  // R1 exact
        '{32'h15113046, 4'd0,  15'h0000, 1'b0, 1'b0, 4'd1},  // R1 seconds differ
        '{32'h151130C6, 4'd0,  15'h0000, 1'b0, 1'b1, 4'd2},  // R2 seconds ignored
        '{32'h15113145, 4'd0,  15'h0000, 1'b0, 1'b0, 4'd2},  // R2 minutes differ
        '{32'h1511B145, 4'd0,  15'h0000, 1'b0, 1'b1, 4'd2},  // R2 minutes ignored
        '{32'h15123045, 4'd0,  15'h0000, 1'b0, 1'b0, 4'd2},  // R2 hour differs
        '{32'h15923045, 4'd0,  15'h0000, 1'b0, 1'b1, 4'd2},  // R2 hour ignored
        '{32'h16113045, 4'd0,  15'h0000, 1'b0, 1'b0, 4'd2},  // R2 day differs
        '{32'h96113045, 4'd0,  15'h0000, 1'b0, 1'b1, 4'd2},  // R2 day ignored
        '{32'h43113045, 4'd0,  15'h0000, 1'b0, 1'b1, 4'd3},  // R3 weekday 3
        '{32'h55113045, 4'd0,  15'h0000, 1'b0, 1'b0, 4'd3},  // R3 weekday vs 15
        '{32'h03113045, 4'd0,  15'h0000, 1'b0, 1'b0, 4'd3},  // R3 date vs 3
        '{32'h15113045, 4'd4,  15'h0004, 1'b0, 1'b1, 4'd4},  // R4 low 4 bits
        '{32'h15113045, 4'd4,  15'h0005, 1'b0, 1'b0, 4'd4},  // R4 low 4 differ
        '{32'h15113045, 4'd15, 15'h1234, 1'b0, 1'b1, 4'd4},  // R4 full width
        '{32'h15113045, 4'd15, 15'h5234, 1'b0, 1'b0, 4'd4},  // R4 bit 14 differs
        '{32'h15113045, 4'd14, 15'h5234, 1'b0, 1'b1, 4'd4},  // R4 bit 14 outside
        '{32'h15113045, 4'd0,  15'h7FFF, 1'b0, 1'b1, 4'd4},  // R4 code 0
        '{32'h15113045, 4'd1,  15'h0001, 1'b0, 1'b0, 4'd4},  // R4 bit 0 differs
        '{32'h15513045, 4'd0,  15'h0000, 1'b0, 1'b1, 4'd5},  // R5 pm ignored in 24h
        '{32'h15513045, 4'd0,  15'h0000, 1'b1, 1'b0, 4'd5},  // R5 pm differs in 12h
        '{32'h15113045, 4'd0,  15'h0000, 1'b1, 1'b1, 4'd5},  // R5 pm equal in 12h
        '{32'h15D13045, 4'd0,  15'h0000, 1'b1, 1'b1, 4'd5},  // R5 pm under hour ignore
        '{32'h1511302D, 4'd0,  15'h0000, 1'b0, 1'b0, 4'd1}   // R1 binary vs BCD
    };

    task automatic check(input logic cond, input string what, input int act, input int exp);
        tests++;
        if (!cond) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic pulse_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    task automatic pulse_clr(input logic [N-1:0] m);
        @(negedge clk) alm_clr = m;
        @(negedge clk) alm_clr = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; tick = 1'b0; mode_12h = 1'b0;
        cal_sec = 7'h45; cal_min = 7'h30; cal_hour = 6'h11; cal_pm = 1'b0;
        cal_day = 6'h15; cal_wday = 3'd3; cal_ss = 15'h1234;
        alm_word = {32'h15113045, 32'h15113045};
        alm_ss_val = '0; alm_ss_code = '0;
        alm_en = 2'b11; alm_ie = 2'b11; alm_clr = '0;
        repeat (3) @(negedge clk);
        // R11: reset holds flags and interrupts low even with matching inputs
        tick = 1'b1;
        @(negedge clk);
        check(alm_flag == 2'b00, "R11 flags under reset", alm_flag, 0);
        check(alm_irq == 2'b00, "R11 irq under reset", alm_irq, 0);
        tick = 1'b0; rst = 1'b0;
        alm_en = 2'b01;

        // Table walk on channel A, channel B disabled
        foreach (VEC[i]) begin
            pulse_clr(2'b11);
            alm_word[31:0] = VEC[i].w;
            alm_ss_code[CW-1:0] = VEC[i].c;
            alm_ss_val[SW-1:0] = VEC[i].v;
            mode_12h = VEC[i].m12;
            pulse_tick();
            if (alm_flag[0] !== VEC[i].exp) begin
                tests++; fails++;
                $display("FAIL R%0d vector %0d: actual %0b expected %0b",
                         VEC[i].rq, i, alm_flag[0], VEC[i].exp);
            end else tests++;
        end
        mode_12h = 1'b0;
        alm_word[31:0] = 32'h15113045;
        alm_ss_code[CW-1:0] = '0;
        alm_ss_val[SW-1:0] = '0;
        pulse_clr(2'b11);

        // R7: matching but disabled channel B never sets
        check(alm_flag[1] == 1'b0, "R7 disabled channel B flag", alm_flag[1], 0);

        // R6: match without tick leaves flag low
        repeat (4) @(negedge clk);
        check(alm_flag[0] == 1'b0, "R6 no tick no flag", alm_flag[0], 0);

        // R8: sticky across a mismatching tick
        pulse_tick();
        check(alm_flag[0] == 1'b1, "R8 set", alm_flag[0], 1);
        cal_sec = 7'h46;
        pulse_tick();
        check(alm_flag[0] == 1'b1, "R8 sticky on mismatch", alm_flag[0], 1);
        pulse_clr(2'b01);
        check(alm_flag[0] == 1'b0, "R8 cleared", alm_flag[0], 0);

        // R8: set and clear together keep the flag
        cal_sec = 7'h45;
        @(negedge clk) begin tick = 1'b1; alm_clr = 2'b01; end
        @(negedge clk) begin tick = 1'b0; alm_clr = 2'b00; end
        check(alm_flag[0] == 1'b1, "R8 set beats clear", alm_flag[0], 1);

        // R9: interrupt follows flag and enable
        check(alm_irq[0] == 1'b1, "R9 irq with ie", alm_irq[0], 1);
        alm_ie = 2'b10;
        @(negedge clk);
        check(alm_irq[0] == 1'b0, "R9 irq masked", alm_irq[0], 0);
        alm_ie = 2'b11;
        pulse_clr(2'b01);
        check(alm_irq[0] == 1'b0, "R9 irq after clear", alm_irq[0], 0);

        // R10: channel B matches alone while A mismatches
        alm_en = 2'b11;
        alm_word = {32'h15113045, 32'h15113046};
        alm_ss_code = {4'd15, 4'd0};
        alm_ss_val = {15'h1234, 15'h0000};
        pulse_tick();
        check(alm_flag == 2'b10, "R10 only B set", alm_flag, 2'b10);
        check(alm_irq == 2'b10, "R10 only B irq", alm_irq, 2'b10);
        pulse_clr(2'b01);
        check(alm_flag == 2'b10, "R10 clear A leaves B", alm_flag, 2'b10);
        pulse_clr(2'b10);
        check(alm_flag == 2'b00, "R10 clear B", alm_flag, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule